// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the address and register-index stream for a multi-register load or store. A start pulse supplies a base address, a 16-bit register mask and two mode bits. The mode bits choose whether addresses go up or down and whether the first word lies one step away from the base or at the base itself. The block then walks the set bits of the mask and presents one word address and one register index per cycle. A consumer accepts each pair with a ready handshake. Registers whose mask bit is clear cost no cycle.

When the last pair is accepted, the block pulses a done strobe and presents the written-back base. That value is the original base moved by four bytes for each set mask bit, in the selected direction. The memory port, the register file and the data path belong to the surrounding core, so this block sends out only addresses, indices and the end-of-sequence strobe.

Top module: `blk_xfer_seq`

## Requirements
- R1: Ascending-after mode (up_i=1, pre_i=0): the first address is the base. Indices come out in rising order. The written-back base is base + 4*N, where N is the number of set mask bits.
- R2: Ascending-before mode (up_i=1, pre_i=1): the first address is base + 4. Indices rise. The written-back base equals the last address sent.
- R3: Descending-after mode (up_i=0, pre_i=0): the first address is the base. Indices come out in falling order, starting from the highest set bit. The written-back base is base - 4*N.
- R4: Descending-before mode (up_i=0, pre_i=1): the first address is base - 4. Indices fall. The written-back base equals the last address sent.
- R5: Each accepted transfer (vld_o=1 and rdy_i=1 at a clock edge) moves the address by exactly 4 in the selected direction. While rdy_i is low, the address and the index hold.
- R6: Clear mask bits are skipped. With rdy_i held high, the N transfers occupy N consecutive cycles that begin in the cycle after start is sampled.
- R7: An all-zero mask produces no transfer. done_o is high in the cycle after start is sampled, with wb_o equal to the base.
- R8: A start pulse sampled while a sequence is running is ignored, and the running sequence continues unchanged.
- R9: Bits [1:0] of addr_o are always zero, even when the base is not word aligned.
- R10: done_o is high for exactly one cycle, the cycle after the last transfer is accepted. vld_o is low in that cycle, and wb_o holds the written-back base.
- R11: After reset, vld_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only while idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register mask; bit k selects register k |
| up_i | input | 1 | 1 = ascending addresses, 0 = descending |
| pre_i | input | 1 | 1 = step before the first access |
| rdy_i | input | 1 | Consumer accepts the current pair |
| busy_o | output | 1 | Sequence in progress |
| vld_o | output | 1 | addr_o and idx_o are valid |
| addr_o | output | 32 | Word address of the current transfer |
| idx_o | output | 4 | Register index of the current transfer |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| wb_o | output | 32 | Written-back base, valid with done_o |

## Verification
The hardest case to reach from the ports is a start request that arrives while a stalled sequence is still running. The pair being presented must stay untouched, and the rest of the walk must stay untouched too. The directed task raises start with a different base and mask in the first cycle of a sequence whose consumer withholds ready on alternate cycles. It then compares every later address, index and the final write-back against the values expected from the original request.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic          up_i,
  input  logic          pre_i,
  input  logic          rdy_i,
  output logic          busy_o,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o,
  output logic [AW-1:0] wb_o
);

  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam int CW = $clog2(NREG + 1);

  logic            busy_q, up_q, done_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, wb_q;
  logic [IW-1:0]   lo_idx, hi_idx, pick;
  logic [NREG-1:0] pick_mask;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span, first_addr;
  logic            start_ok, fire, last;

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) lo_idx = IW'(i);
    for (int i = 0; i < NREG; i++)
      if (rem_q[i]) hi_idx = IW'(i);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++)
      cnt = cnt + CW'(mask_i[i]);
  end

  assign pick       = up_q ? lo_idx : hi_idx;
  assign pick_mask  = NREG'(1) << pick;
  assign last       = (rem_q & ~pick_mask) == '0;
  assign start_ok   = start_i && !busy_q;
  assign fire       = busy_q && rdy_i;
  assign span       = AW'(cnt) << 2;
  assign first_addr = !pre_i ? base_i : (up_i ? base_i + WSTEP : base_i - WSTEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      up_q   <= 1'b1;
      done_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      wb_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        rem_q  <= mask_i;
        up_q   <= up_i;
        busy_q <= |mask_i;
        done_q <= ~|mask_i;
        addr_q <= first_addr;
        wb_q   <= up_i ? base_i + span : base_i - span;
      end else if (fire) begin
        rem_q  <= rem_q & ~pick_mask;
        addr_q <= up_q ? addr_q + WSTEP : addr_q - WSTEP;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign vld_o  = busy_q;
  assign addr_o = {addr_q[AW-1:2], 2'b00};
  assign idx_o  = pick;
  assign done_o = done_q;
  assign wb_o   = wb_q;

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && rdy_i && !last |=> addr_o == ($past(up_q) ? $past(addr_o) + WSTEP : $past(addr_o) - WSTEP));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && !rdy_i |=> vld_o && $stable(addr_o) && $stable(idx_o));

  // R1
  order_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && rdy_i && !last && up_q |=> idx_o > $past(idx_o));

  // R3
  order_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && rdy_i && !last && !up_q |=> idx_o < $past(idx_o));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && rdy_i && last |=> done_o && !vld_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !rdy_i |=> busy_o && $stable(addr_o) && $stable(idx_o));

endmodule

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        start_i = 0, up_i = 0, pre_i = 0, rdy_i = 0;
  logic [31:0] base_i = 0;
  logic [15:0] mask_i = 0;
  logic        busy_o, vld_o, done_o;
  logic [31:0] addr_o, wb_o;
  logic [3:0]  idx_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  blk_xfer_seq u_dut (.clk, .rst_n, .start_i, .base_i, .mask_i, .up_i, .pre_i,
    .rdy_i, .busy_o, .vld_o, .addr_o, .idx_o, .done_o, .wb_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_seq(input string req, input logic [31:0] base, input logic [15:0] mask,
                         input logic up, input logic pre, input bit stall, input bit poke);
    logic [31:0] a0, exp_wb;
    int idxs[$];
    int n, k, cyc;
    if (up) begin for (int i = 0; i < 16; i++) if (mask[i]) idxs.push_back(i); end
    else    begin for (int i = 15; i >= 0; i--) if (mask[i]) idxs.push_back(i); end
    n = idxs.size();
    a0 = pre ? (up ? base + 4 : base - 4) : base;
    exp_wb = up ? base + 4*n : base - 4*n;
    @(negedge clk);
    start_i = 1; base_i = base; mask_i = mask; up_i = up; pre_i = pre; rdy_i = 0;
    @(negedge clk);
    start_i = 0;
    k = 0; cyc = 0;
    while (k < n && cyc < 200) begin
      chk({req, " valid"}, 32'(vld_o), 32'd1);
      chk({req, " R9 addr"}, addr_o, (up ? a0 + 4*k : a0 - 4*k) & 32'hFFFF_FFFC);
      chk({req, " idx"}, 32'(idx_o), 32'(idxs[k]));
      rdy_i = stall ? cyc[0] : 1'b1;
      if (poke && cyc == 0) begin
        start_i = 1; base_i = 32'h5555_0000; mask_i = 16'hFFFF; up_i = ~up; pre_i = ~pre;
      end else start_i = 0;
      if (rdy_i) k++;
      cyc++;
      @(negedge clk);
    end
    start_i = 0;
    rdy_i = 0;
    if (!stall) chk({req, " R6 cycles"}, 32'(cyc), 32'(n));
    chk({req, " R10 done"}, 32'(done_o), 32'd1);
    chk({req, " R10 vld low"}, 32'(vld_o), 32'd0);
    chk({req, " wb"}, wb_o, exp_wb);
    if (pre && n > 0) chk({req, " wb=last"}, wb_o, up ? a0 + 4*(n-1) : a0 - 4*(n-1));
    @(negedge clk);
    chk({req, " R10 pulse"}, 32'(done_o), 32'd0);
    chk({req, " busy clear"}, 32'(busy_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 vld", 32'(vld_o), 0);
    chk("R11 done", 32'(done_o), 0);
    chk("R11 busy", 32'(busy_o), 0);
  endtask

  task automatic t_empty;
    @(negedge clk);
    start_i = 1; base_i = 32'h4000_0100; mask_i = 0; up_i = 1; pre_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R7 done", 32'(done_o), 1);
    chk("R7 no valid", 32'(vld_o), 0);
    chk("R7 wb", wb_o, 32'h4000_0100);
    @(negedge clk);
    chk("R7 pulse", 32'(done_o), 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_seq("R1 up-after",  32'h4000_0100, 16'b0000_0000_0000_1110, 1, 0, 0, 0);
    run_seq("R2 up-before", 32'h4000_0100, 16'b1000_0000_0001_0001, 1, 1, 0, 0);
    run_seq("R3 dn-after",  32'h4000_0100, 16'b0100_0010_0000_1001, 0, 0, 0, 0);
    run_seq("R4 dn-before", 32'h4000_0100, 16'b1000_0000_0000_0011, 0, 1, 0, 0);
    run_seq("R6 sparse",    32'h2000_0040, 16'b1010_0000_0100_0001, 1, 0, 0, 0);
    run_seq("R6 full",      32'h2000_0200, 16'hFFFF, 0, 1, 0, 0);
    run_seq("R5 stall",     32'h1000_0000, 16'b0000_0111_0000_0000, 1, 1, 1, 0);
    run_seq("R8 poke",      32'h1000_0080, 16'b0011_0000_0000_0110, 0, 0, 1, 1);
    run_seq("R9 unaligned", 32'h3000_0013, 16'b0000_0000_0101_0000, 1, 1, 0, 0);
    run_seq("R1 single",    32'h0000_0000, 16'b1000_0000_0000_0000, 1, 0, 0, 0);
    t_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule